// File: doc/BRIEF.md
# Dead-Zone Phase Comparator

This block is the digital phase/frequency comparator of a PLL synthesizer. It watches two edge streams, one from the divided reference and one from the divided oscillator. It drives raise and lower enables to an external charge pump. A rising reference edge arms the raise side. A rising oscillator edge arms the lower side. Once both sides are armed, both are released on the following clock.

A two-bit select chooses one of four dead zones. The widths, counted in system clocks, grow strictly from the first mode to the last. An error no longer than the chosen width produces no pump pulse. A longer error is shortened by that width. The raw error pulse is exported separately, with no dead zone applied, so that a lock detector can measure the true misalignment.

A deadlock-clear control can override the pump. While it is active, the lower enable is held high and the raise enable is held low. This pulls the tuning node to the rail, which restarts an oscillator that stalled when its control voltage collapsed. Both the mode select and the override are taken only on a rising reference edge, so a pump pulse already in progress is never cut or stretched by a control change.

Top module: `dz_phase_cmp`

## Requirements
- R1: After reset, `up_o`, `dn_o` and `phase_err_o` are 0, the latched mode is 00 and the override is off.
- R2: A rising edge on `ref_i` arms the raise side on the next clock. A rising edge on `vco_i` arms the lower side on the next clock. A second edge on a side that is already armed changes nothing.
- R3: The clock after both sides are armed, both are cleared. Rising edges on `ref_i` and `vco_i` in the same cycle therefore give one cycle of `phase_err_o` and no pump pulse.
- R4: The mode select `dz_sel_i` maps 00/01/10/11 to dead zones of `DZ_W_A`/`DZ_W_B`/`DZ_W_C`/`DZ_W_D` clocks (defaults 0/2/4/8).
- R5: When the reference leads by E cycles and the dead zone is W, `up_o` is high for max(E-W,0) cycles.
- R6: When the oscillator leads by E cycles and the dead zone is W, `dn_o` is high for max(E-W,0) cycles.
- R7: `phase_err_o` is high while either side is armed, so it lasts E+1 cycles for a lead of E cycles. The dead zone does not affect it.
- R8: While the latched override is 1, `dn_o` is 1 and `up_o` is 0 on every cycle, whatever the edges.
- R9: `dz_sel_i` and `force_low_i` are latched only on a rising `ref_i` edge. The latched value applies from the next clock. Changes between reference edges have no effect.
- R10: `up_o` and `dn_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_i | input | 1 | Divided reference stream (rising edge significant) |
| vco_i | input | 1 | Divided oscillator stream (rising edge significant) |
| dz_sel_i | input | 2 | Dead-zone mode select |
| force_low_i | input | 1 | Deadlock-clear request, 1 forces pump low |
| up_o | output | 1 | Charge-pump raise enable |
| dn_o | output | 1 | Charge-pump lower enable |
| phase_err_o | output | 1 | Raw phase-error pulse for lock detection |

## Verification
An input edge that is present before clock k appears in the armed state, and in `phase_err_o`, right after clock k. The pump outputs of a lone side follow after W more clocks of the same lone interval. A latched mode or override takes effect from the clock that records the reference edge. The bench drives inputs on falling edges and samples on the following falling edge. For each scenario it counts the high cycles of every output over a window that extends past the clear cycle. Comparing these counts with E+1 and max(E-W,0) keeps each check aligned with the stated latency, independent of the exact starting cycle.

// File: rtl/dz_phase_cmp_pkg.sv
package dz_phase_cmp_pkg;

  typedef enum logic [1:0] {
    DZ_MODE_A = 2'b00,
    DZ_MODE_B = 2'b01,
    DZ_MODE_C = 2'b10,
    DZ_MODE_D = 2'b11
  } dz_mode_e;

  typedef struct packed {
    logic up;
    logic dn;
  } arm_t;

  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_REF = 0;
  localparam int unsigned CH_VCO = 1;

endpackage

// File: rtl/dz_edge_det.sv
module dz_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);

  logic sig_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sig_q <= 1'b0;
    else         sig_q <= sig_i;
  end

  assign rise_o = sig_i & ~sig_q;

endmodule

// File: rtl/dz_arm_core.sv
module dz_arm_core
  import dz_phase_cmp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_rise_i,
  input  logic vco_rise_i,
  output arm_t arm_o
);

  arm_t arm_q, arm_d;

  // clear wins over a same-cycle edge
  always_comb begin
    arm_d = arm_q;
    if (arm_q.up && arm_q.dn) begin
      arm_d.up = 1'b0;
      arm_d.dn = 1'b0;
    end else begin
      arm_d.up = arm_q.up | ref_rise_i;
      arm_d.dn = arm_q.dn | vco_rise_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) arm_q <= '0;
    else         arm_q <= arm_d;
  end

  assign arm_o = arm_q;

endmodule

// File: rtl/dz_pump_gate.sv
module dz_pump_gate
  import dz_phase_cmp_pkg::*;
#(
  parameter int unsigned DZ_W_A = 0,
  parameter int unsigned DZ_W_B = 2,
  parameter int unsigned DZ_W_C = 4,
  parameter int unsigned DZ_W_D = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_rise_i,
  input  logic [1:0] dz_sel_i,
  input  logic       force_low_i,
  input  arm_t       arm_i,
  output logic       up_o,
  output logic       dn_o
);

  localparam int unsigned WMAX  = (DZ_W_D > DZ_W_C) ? DZ_W_D : DZ_W_C;
  localparam int unsigned CNT_W = $clog2(WMAX + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WMAX);

  dz_mode_e         mode_q;
  logic             frc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] width;
  logic             lone;
  logic             open_win;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= DZ_MODE_A;
      frc_q  <= 1'b0;
    end else if (ref_rise_i) begin
      mode_q <= dz_mode_e'(dz_sel_i);
      frc_q  <= force_low_i;
    end
  end

  always_comb begin
    unique case (mode_q)
      DZ_MODE_A: width = CNT_W'(DZ_W_A);
      DZ_MODE_B: width = CNT_W'(DZ_W_B);
      DZ_MODE_C: width = CNT_W'(DZ_W_C);
      default:   width = CNT_W'(DZ_W_D);
    endcase
  end

  assign lone = arm_i.up ^ arm_i.dn;

  // cycles already spent with one side armed alone, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!lone)          cnt_q <= '0;
    else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
  end

  assign open_win = lone && (cnt_q >= width);

  assign up_o = !frc_q && open_win && arm_i.up;
  assign dn_o =  frc_q || (open_win && arm_i.dn);

endmodule

// File: rtl/dz_phase_cmp.sv
module dz_phase_cmp
  import dz_phase_cmp_pkg::*;
#(
  parameter int unsigned DZ_W_A = 0,
  parameter int unsigned DZ_W_B = 2,
  parameter int unsigned DZ_W_C = 4,
  parameter int unsigned DZ_W_D = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ref_i,
  input  logic       vco_i,
  input  logic [1:0] dz_sel_i,
  input  logic       force_low_i,
  output logic       up_o,
  output logic       dn_o,
  output logic       phase_err_o
);

  logic [NUM_CH-1:0] sig_in;
  logic [NUM_CH-1:0] rise;
  arm_t              arm;

  assign sig_in[CH_REF] = ref_i;
  assign sig_in[CH_VCO] = vco_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_edge
    dz_edge_det i_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sig_i  (sig_in[g]),
      .rise_o (rise[g])
    );
  end

  dz_arm_core i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ref_rise_i (rise[CH_REF]),
    .vco_rise_i (rise[CH_VCO]),
    .arm_o      (arm)
  );

  dz_pump_gate #(
    .DZ_W_A (DZ_W_A),
    .DZ_W_B (DZ_W_B),
    .DZ_W_C (DZ_W_C),
    .DZ_W_D (DZ_W_D)
  ) i_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_rise_i  (rise[CH_REF]),
    .dz_sel_i    (dz_sel_i),
    .force_low_i (force_low_i),
    .arm_i       (arm),
    .up_o        (up_o),
    .dn_o        (dn_o)
  );

  assign phase_err_o = arm.up | arm.dn;

endmodule

// File: rtl/dz_phase_cmp_chk.sv
module dz_phase_cmp_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ref_i,
  input logic vco_i,
  input logic force_low_i,
  input logic up_o,
  input logic dn_o,
  input logic phase_err_o
);

  assert_no_overlap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(up_o && dn_o));

  assert_force_latch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ref_i) && force_low_i) |=> (dn_o && !up_o));

  assert_same_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phase_err_o && $rose(ref_i) && $rose(vco_i) && !force_low_i)
      |=> (phase_err_o && !up_o && !dn_o) ##1 !phase_err_o);

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phase_err_o && !$rose(ref_i) && !$rose(vco_i)) |=> !phase_err_o);

  assert_up_raw_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_o |-> phase_err_o);

endmodule

bind dz_phase_cmp dz_phase_cmp_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ref_i       (ref_i),
  .vco_i       (vco_i),
  .force_low_i (force_low_i),
  .up_o        (up_o),
  .dn_o        (dn_o),
  .phase_err_o (phase_err_o)
);

// File: tb/test_dz_phase_cmp.sv
module test_dz_phase_cmp;

  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ref_i = 1'b0;
  logic       vco_i = 1'b0;
  logic [1:0] dz_sel_i = 2'b00;
  logic       force_low_i = 1'b0;
  logic       up_o, dn_o, phase_err_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dz_phase_cmp i_dz_phase_cmp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_i       (ref_i),
    .vco_i       (vco_i),
    .dz_sel_i    (dz_sel_i),
    .force_low_i (force_low_i),
    .up_o        (up_o),
    .dn_o        (dn_o),
    .phase_err_o (phase_err_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int dz_width(input logic [1:0] m);
    case (m)
      2'b00:   return 0;
      2'b01:   return 2;
      2'b10:   return 4;
      default: return 8;
    endcase
  endfunction

  function automatic int sat_sub(input int e, input int w);
    return (e > w) ? e - w : 0;
  endfunction

  // lead side gets its edge at t=0, the other at t=e; counts sampled highs
  task automatic run_pair(input bit ref_lead, input int e,
                          output int n_up, output int n_dn, output int n_pe);
    int win;
    win = e + 4;
    n_up = 0; n_dn = 0; n_pe = 0;
    for (int t = 0; t < win; t++) begin
      @(negedge clk_i);
      if (t > 0) begin
        n_up += int'(up_o);
        n_dn += int'(dn_o);
        n_pe += int'(phase_err_o);
      end
      ref_i = ref_lead ? (t == 0) : (t == e);
      vco_i = ref_lead ? (t == e) : (t == 0);
    end
    @(negedge clk_i);
    n_up += int'(up_o);
    n_dn += int'(dn_o);
    n_pe += int'(phase_err_o);
    ref_i = 1'b0;
    vco_i = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1 up", int'(up_o), 0);
    chk("R1 dn", int'(dn_o), 0);
    chk("R1 perr", int'(phase_err_o), 0);
  endtask

  task automatic t_same_edge;
    int u, d, p;
    run_pair(1'b1, 0, u, d, p);
    chk("R3 perr cycles", p, 1);
    chk("R3 up cycles", u, 0);
    chk("R3 dn cycles", d, 0);
  endtask

  task automatic t_ref_lead(input logic [1:0] m, input int e);
    int u, d, p;
    dz_sel_i = m;
    run_pair(1'b1, e, u, d, p);
    chk($sformatf("R5 R4 up mode=%0d e=%0d", m, e), u, sat_sub(e, dz_width(m)));
    chk($sformatf("R5 dn mode=%0d e=%0d", m, e), d, 0);
    chk($sformatf("R7 R2 perr e=%0d", e), p, e + 1);
  endtask

  task automatic t_vco_lead(input logic [1:0] latched, input int e);
    int u, d, p;
    run_pair(1'b0, e, u, d, p);
    chk($sformatf("R6 dn mode=%0d e=%0d", latched, e), d, sat_sub(e, dz_width(latched)));
    chk($sformatf("R6 up e=%0d", e), u, 0);
    chk($sformatf("R7 perr vco e=%0d", e), p, e + 1);
  endtask

  task automatic t_mode_hold;
    // latch mode D, then change select without a reference edge
    t_ref_lead(2'b11, 1);
    dz_sel_i = 2'b00;
    t_vco_lead(2'b11, 3);
  endtask

  task automatic t_force;
    int u, d, p;
    dz_sel_i = 2'b00;
    force_low_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R9 force not yet latched", int'(dn_o), 0);
    run_pair(1'b1, 2, u, d, p);
    chk("R8 dn forced cycles", d, 6);
    chk("R8 up blocked", u, 0);
    chk("R8 perr unaffected", p, 3);
    force_low_i = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R9 force held until ref", int'(dn_o), 1);
    run_pair(1'b1, 3, u, d, p);
    chk("R8 normal up after release", u, 3);
    chk("R8 dn after release", d, 0);
  endtask

  task automatic t_double_ref;
    int n_up;
    dz_sel_i = 2'b00;
    n_up = 0;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk_i);
      if (t > 0) n_up += int'(up_o);
      ref_i = (t == 0) || (t == 2);
      vco_i = (t == 5);
    end
    for (int t = 0; t < 3; t++) begin
      @(negedge clk_i);
      n_up += int'(up_o);
      ref_i = 1'b0;
      vco_i = 1'b0;
    end
    chk("R2 second ref ignored", n_up, 5);
    chk("R3 idle after clear", int'(phase_err_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset;
    t_same_edge;
    t_ref_lead(2'b00, 3);
    t_ref_lead(2'b01, 2);
    t_ref_lead(2'b01, 3);
    t_ref_lead(2'b10, 3);
    t_ref_lead(2'b10, 6);
    t_ref_lead(2'b11, 8);
    t_ref_lead(2'b11, 10);
    t_ref_lead(2'b10, 0);
    t_vco_lead(2'b10, 5);
    t_ref_lead(2'b00, 1);
    t_vco_lead(2'b00, 4);
    t_mode_hold;
    t_force;
    t_double_ref;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule